// File: doc/BRIEF.md
# Resumable Bit Scan Unit

This block locates set bits in a 32-bit mask word. Its combinational scan port finds the lowest set bit when scanning forward and the highest set bit when scanning in reverse. The same port can also resume a search just past a supplied bit position. Software or a sequencer can continue a search by feeding each returned index back in as the next start position. The mask never has to be edited to knock out bits already found.

A second, registered port serialises a whole mask. A one-cycle start pulse captures a mask and a direction. From the following cycle on, the unit presents one set-bit index per clock, with a valid flag, in ascending or descending order. It raises a last flag alongside the final index and then falls idle. This turns the lane mask of a vector result into a stream of scalar work items.

Top module: `bitscan_unit`

## Requirements
- R1: With resume low and reverse low, the scan port returns the index of the lowest set bit of `scanMask`.
- R2: With resume low and reverse high, the scan port returns the index of the highest set bit of `scanMask`.
- R3: With resume high and reverse low, only bits whose index is strictly greater than `scanFrom` qualify. `scanFrom` is read as a 6-bit two's complement number, so 6'b111111 (-1) gives the same result as R1.
- R4: With resume high and reverse high, only bits whose index is strictly less than `scanFrom` qualify, and the highest of them is returned. `scanFrom` is read as unsigned, so 32 gives the same result as R2.
- R5: When no bit qualifies, `scanNone` is 1 and `scanIndex` is 0. Examples are an empty mask, a forward resume from 31, and a reverse resume from 0.
- R6: Feeding each returned index back as `scanFrom` visits every set bit exactly once, in scan order, with the mask held constant.
- R7: From the cycle after an `itStart` pulse on a non-empty `itMask`, `itValid` is 1 for one cycle per set bit. The indices come in ascending order when `itReverse` was 0 and in descending order when it was 1.
- R8: `itLast` is 1 only together with the final index, and `itValid` is 0 in the cycle after it.
- R9: An `itStart` pulse with an all-zero `itMask` leaves `itValid` at 0.
- R10: An `itStart` pulse during a walk abandons it, and the next cycle presents the first index of the new mask.
- R11: After reset, `itValid` and `itLast` are 0 and `itIndex` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scanMask | input | 32 | Mask searched by the combinational port |
| scanReverse | input | 1 | 0 = search upward, 1 = search downward |
| scanResume | input | 1 | 1 = start just past `scanFrom` |
| scanFrom | input | 6 | Resume position (signed forward, unsigned reverse) |
| scanIndex | output | 5 | Index found, 0 when none |
| scanNone | output | 1 | No qualifying bit |
| itStart | input | 1 | One-cycle pulse that loads the iterator |
| itMask | input | 32 | Mask captured by `itStart` |
| itReverse | input | 1 | Iterator direction captured by `itStart` |
| itValid | output | 1 | `itIndex` holds a set-bit index this cycle |
| itIndex | output | 5 | Current set-bit index, 0 when idle |
| itLast | output | 1 | Current index is the final set bit |

## Verification
The bench builds the unit at its default width of 32. That makes the 6-bit start field reach both sentinels: -1 for forward and 32 for reverse. It also makes both edge bits, 0 and 31, reachable. The corner cases at the ends of the range are therefore covered: a forward resume from 31, a reverse resume from 0, a mask with only bit 31 set, and the full all-ones mask. The full mask drives a 32-cycle iterator walk in each direction.

// File: rtl/bscan_pkg.sv
`timescale 1ns/1ps
package bscan_pkg;
  // strobes from control to datapath for the iterator
  typedef struct packed {
    logic load;   // capture mask, direction and seed position
    logic step;   // move position to the index just emitted
  } itStrobe_t;
endpackage

// File: rtl/bscan_core.sv
`timescale 1ns/1ps
// Combinational qualified priority search over one mask word.
module bscan_core #(
  parameter int WIDTH = 32,
  localparam int IDXW = $clog2(WIDTH),
  localparam int POSW = IDXW + 1
) (
  input  logic [WIDTH-1:0] mask,
  input  logic             reverse,
  input  logic             resume,
  input  logic [POSW-1:0]  from,
  output logic [IDXW-1:0]  index,
  output logic             none
);
  logic [WIDTH-1:0] qual;
  logic signed [POSW-1:0] fromS;

  assign fromS = $signed(from);

  // window: forward keeps bits above the signed start, reverse keeps bits below the unsigned start
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_qual
      assign qual[i] = mask[i] &
        (!resume | (reverse ? (int'(from) > i) : (int'(fromS) < i)));
    end
  endgenerate

  always_comb begin
    index = '0;
    none  = 1'b1;
    if (reverse) begin
      for (int i = 0; i < WIDTH; i++) begin
        if (qual[i]) begin
          index = IDXW'(i);
          none  = 1'b0;
        end
      end
    end else begin
      for (int i = WIDTH - 1; i >= 0; i--) begin
        if (qual[i]) begin
          index = IDXW'(i);
          none  = 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/bscan_datapath.sv
`timescale 1ns/1ps
module bscan_datapath
  import bscan_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int IDXW = $clog2(WIDTH),
  localparam int POSW = IDXW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] scanMask,
  input  logic             scanReverse,
  input  logic             scanResume,
  input  logic [POSW-1:0]  scanFrom,
  output logic [IDXW-1:0]  scanIndex,
  output logic             scanNone,
  input  logic [WIDTH-1:0] itMask,
  input  logic             itReverse,
  input  itStrobe_t        strb,
  output logic             inMaskEmpty,
  output logic             curValid,
  output logic             curLast,
  output logic [IDXW-1:0]  curIdx
);
  localparam logic [POSW-1:0] FWD_SEED = '1;
  localparam logic [POSW-1:0] REV_SEED = POSW'(WIDTH);

  logic [WIDTH-1:0] itMaskQ;
  logic             itRevQ;
  logic [POSW-1:0]  posQ;
  logic             curNone;
  logic             nxtNone;
  logic [IDXW-1:0]  nxtIdx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      itMaskQ <= '0;
      itRevQ  <= 1'b0;
      posQ    <= FWD_SEED;
    end else if (strb.load) begin
      itMaskQ <= itMask;
      itRevQ  <= itReverse;
      posQ    <= itReverse ? REV_SEED : FWD_SEED;
    end else if (strb.step) begin
      posQ <= {1'b0, curIdx};
    end
  end

  bscan_core #(.WIDTH(WIDTH)) u_user (
    .mask(scanMask), .reverse(scanReverse), .resume(scanResume),
    .from(scanFrom), .index(scanIndex), .none(scanNone));

  bscan_core #(.WIDTH(WIDTH)) u_cur (
    .mask(itMaskQ), .reverse(itRevQ), .resume(1'b1),
    .from(posQ), .index(curIdx), .none(curNone));

  // lookahead: is there anything past the current index?
  bscan_core #(.WIDTH(WIDTH)) u_nxt (
    .mask(itMaskQ), .reverse(itRevQ), .resume(1'b1),
    .from({1'b0, curIdx}), .index(nxtIdx), .none(nxtNone));

  assign inMaskEmpty = ~|itMask;
  assign curValid    = !curNone;
  assign curLast     = !curNone && nxtNone;

  // R1 / R2: a reported bit is really set
  a_r1_hit_is_set: assert property (@(posedge clk) disable iff (!rst_n)
    !scanNone |-> scanMask[scanIndex]);
  // R5
  a_r5_none_zero: assert property (@(posedge clk) disable iff (!rst_n)
    scanNone |-> (scanIndex == '0));
  // R3
  a_r3_above_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!scanNone && scanResume && !scanReverse) |-> (int'(scanIndex) > int'($signed(scanFrom))));
  // R4
  a_r4_below_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!scanNone && scanResume && scanReverse) |-> (int'(scanIndex) < int'(scanFrom)));
  // R7: each step lands on a further bit in the walk direction
  a_r7_ordered_step: assert property (@(posedge clk) disable iff (!rst_n)
    strb.step |=> (curValid && (itRevQ ? (curIdx < $past(curIdx)) : (curIdx > $past(curIdx)))));
  // R6: the lookahead never reports a bit behind the current one
  a_r6_lookahead_order: assert property (@(posedge clk) disable iff (!rst_n)
    (curValid && !nxtNone) |-> (itRevQ ? (nxtIdx < curIdx) : (nxtIdx > curIdx)));
endmodule

// File: rtl/bscan_ctrl.sv
`timescale 1ns/1ps
module bscan_ctrl
  import bscan_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      itStart,
  input  logic      inMaskEmpty,
  input  logic      curValid,
  input  logic      curLast,
  output itStrobe_t strb,
  output logic      running
);
  typedef enum logic {S_IDLE, S_RUN} state_t;
  state_t state;

  assign running = (state == S_RUN);

  always_comb begin
    strb.load = itStart;
    strb.step = running && !itStart && curValid && !curLast;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
    end else if (itStart) begin
      state <= inMaskEmpty ? S_IDLE : S_RUN;
    end else if (running && (curLast || !curValid)) begin
      state <= S_IDLE;
    end
  end

  // R8
  a_r8_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (running && curLast && !itStart) |=> !running);
  // R9
  a_r9_empty_start: assert property (@(posedge clk) disable iff (!rst_n)
    (itStart && inMaskEmpty) |=> !running);
  // R7: a walk always has a bit in front of it
  a_r7_run_has_bit: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> curValid);
  // R10
  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (itStart && !inMaskEmpty) |=> running);
endmodule

// File: rtl/bitscan_unit.sv
`timescale 1ns/1ps
module bitscan_unit
  import bscan_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int IDXW = $clog2(WIDTH),
  localparam int POSW = IDXW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] scanMask,
  input  logic             scanReverse,
  input  logic             scanResume,
  input  logic [POSW-1:0]  scanFrom,
  output logic [IDXW-1:0]  scanIndex,
  output logic             scanNone,
  input  logic             itStart,
  input  logic [WIDTH-1:0] itMask,
  input  logic             itReverse,
  output logic             itValid,
  output logic [IDXW-1:0]  itIndex,
  output logic             itLast
);
  itStrobe_t       strb;
  logic            running;
  logic            inMaskEmpty;
  logic            curValid;
  logic            curLast;
  logic [IDXW-1:0] curIdx;

  bscan_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .itStart(itStart), .inMaskEmpty(inMaskEmpty),
    .curValid(curValid), .curLast(curLast), .strb(strb), .running(running));

  bscan_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .scanMask(scanMask), .scanReverse(scanReverse), .scanResume(scanResume),
    .scanFrom(scanFrom), .scanIndex(scanIndex), .scanNone(scanNone),
    .itMask(itMask), .itReverse(itReverse), .strb(strb),
    .inMaskEmpty(inMaskEmpty), .curValid(curValid), .curLast(curLast),
    .curIdx(curIdx));

  assign itValid = running && curValid;
  assign itLast  = running && curLast;
  assign itIndex = running ? curIdx : '0;

  // R11
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !itValid |-> (!itLast && itIndex == '0));
endmodule

// File: tb/sim_bitscan_unit.sv
`timescale 1ns/1ps
module sim_bitscan_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] scanMask = '0;
  logic        scanReverse = 1'b0;
  logic        scanResume = 1'b0;
  logic [5:0]  scanFrom = '0;
  logic [4:0]  scanIndex;
  logic        scanNone;
  logic        itStart = 1'b0;
  logic [31:0] itMask = '0;
  logic        itReverse = 1'b0;
  logic        itValid;
  logic [4:0]  itIndex;
  logic        itLast;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bitscan_unit u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // reference: -1 means nothing qualifies
  function automatic int refScan(input logic [31:0] m, input bit rev, input bit res, input logic [5:0] f);
    int lo, hi, sf;
    sf = int'(f);
    if (sf >= 32 && !rev) sf -= 64;
    if (!rev) begin
      lo = res ? sf + 1 : 0;
      if (lo < 0) lo = 0;
      for (int i = lo; i < 32; i++) if (m[i]) return i;
    end else begin
      hi = res ? int'(f) - 1 : 31;
      if (hi > 31) hi = 31;
      for (int i = hi; i >= 0; i--) if (m[i]) return i;
    end
    return -1;
  endfunction

  task automatic scanChk(input string req, input logic [31:0] m, input bit rev, input bit res, input logic [5:0] f);
    int e;
    scanMask = m; scanReverse = rev; scanResume = res; scanFrom = f;
    #1;
    e = refScan(m, rev, res, f);
    chk(req, int'(scanNone), (e < 0) ? 1 : 0);
    chk(req, int'(scanIndex), (e < 0) ? 0 : e);
  endtask

  task automatic t_reset();
    chk("R11 valid", int'(itValid), 0);
    chk("R11 last", int'(itLast), 0);
    chk("R11 index", int'(itIndex), 0);
  endtask

  task automatic t_plain();
    logic [31:0] pats [6] = '{32'h0000_0001, 32'h8000_0000, 32'hFFFF_FFFF,
                              32'h0010_0400, 32'h7000_000E, 32'h0001_0000};
    foreach (pats[k]) begin
      scanChk("R1", pats[k], 1'b0, 1'b0, 6'd0);
      scanChk("R2", pats[k], 1'b1, 1'b0, 6'd0);
    end
    for (int k = 0; k < 20; k++) begin
      logic [31:0] m = $urandom() | 32'h1;
      scanChk("R1", m, 1'b0, 1'b0, 6'($urandom()));
      scanChk("R2", m, 1'b1, 1'b0, 6'($urandom()));
    end
  endtask

  task automatic t_resume();
    logic [31:0] m = 32'hA5C3_0810;
    for (int f = 0; f < 64; f++) begin
      scanChk("R3", m, 1'b0, 1'b1, 6'(f));
      scanChk("R4", m, 1'b1, 1'b1, 6'(f));
    end
    // sentinels match plain scans
    scanMask = m; scanReverse = 0; scanResume = 1; scanFrom = 6'h3F; #1;
    chk("R3 sentinel", int'(scanIndex), 4);
    scanReverse = 1; scanFrom = 6'd32; #1;
    chk("R4 sentinel", int'(scanIndex), 31);
  endtask

  task automatic t_none();
    scanChk("R5 empty fwd", 32'h0, 1'b0, 1'b0, 6'd0);
    scanChk("R5 empty rev", 32'h0, 1'b1, 1'b0, 6'd0);
    scanChk("R5 fwd from 31", 32'hFFFF_FFFF, 1'b0, 1'b1, 6'd31);
    scanChk("R5 rev from 0", 32'hFFFF_FFFF, 1'b1, 1'b1, 6'd0);
  endtask

  task automatic t_chain(input logic [31:0] m, input bit rev);
    int cnt = 0, prev;
    logic [5:0] f = rev ? 6'd32 : 6'h3F;
    prev = rev ? 32 : -1;
    scanMask = m; scanReverse = rev; scanResume = 1;
    for (int k = 0; k < 40; k++) begin
      scanFrom = f; #1;
      if (scanNone) break;
      cnt++;
      chk("R6 set bit", int'(m[scanIndex]), 1);
      chk("R6 order", int'(rev ? (int'(scanIndex) < prev) : (int'(scanIndex) > prev)), 1);
      prev = int'(scanIndex);
      f = {1'b0, scanIndex};
    end
    chk("R6 count", cnt, $countones(m));
  endtask

  task automatic t_iter(input logic [31:0] m, input bit rev);
    int exp [32];
    int n = 0;
    if (rev) begin for (int i = 31; i >= 0; i--) if (m[i]) begin exp[n] = i; n++; end end
    else     begin for (int i = 0; i < 32; i++)  if (m[i]) begin exp[n] = i; n++; end end
    @(negedge clk);
    itStart = 1; itMask = m; itReverse = rev;
    @(posedge clk); #1;
    itStart = 0;
    for (int k = 0; k < n; k++) begin
      if (k > 0) begin @(posedge clk); #1; end
      chk("R7 valid", int'(itValid), 1);
      chk("R7 index", int'(itIndex), exp[k]);
      chk("R8 last", int'(itLast), (k == n - 1) ? 1 : 0);
    end
    @(posedge clk); #1;
    chk("R8 done", int'(itValid), 0);
  endtask

  task automatic t_iter_empty();
    @(negedge clk);
    itStart = 1; itMask = 0; itReverse = 0;
    @(posedge clk); #1;
    itStart = 0;
    for (int k = 0; k < 3; k++) begin
      chk("R9 no valid", int'(itValid), 0);
      @(posedge clk); #1;
    end
  endtask

  task automatic t_restart();
    @(negedge clk);
    itStart = 1; itMask = 32'h0000_FF00; itReverse = 0;
    @(posedge clk); #1;
    itStart = 0;
    chk("R10 first A", int'(itIndex), 8);
    @(posedge clk); #1;
    chk("R10 second A", int'(itIndex), 9);
    itStart = 1; itMask = 32'h0420_0000; itReverse = 1;
    @(posedge clk); #1;
    itStart = 0;
    chk("R10 first B", int'(itIndex), 26);
    chk("R10 valid B", int'(itValid), 1);
    @(posedge clk); #1;
    chk("R10 second B", int'(itIndex), 21);
    chk("R10 last B", int'(itLast), 1);
    @(posedge clk); #1;
    chk("R10 idle", int'(itValid), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_plain();
    t_resume();
    t_none();
    t_chain(32'hA5C3_0810, 1'b0);
    t_chain(32'hA5C3_0810, 1'b1);
    t_chain(32'hFFFF_FFFF, 1'b0);
    t_iter(32'h8000_0421, 1'b0);
    t_iter(32'h8000_0421, 1'b1);
    t_iter(32'hFFFF_FFFF, 1'b0);
    t_iter(32'hFFFF_FFFF, 1'b1);
    t_iter(32'h8000_0000, 1'b0);
    t_iter(32'h0000_0001, 1'b1);
    t_iter_empty();
    t_restart();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule